// File: doc/BRIEF.md
# Per-Timeslot Output Attenuation Stage

This block is the last stage on the send side of a multi-channel echo canceller. Speech samples arrive time-multiplexed, one timeslot per valid cycle. Each sample comes with two values: the original send-path sample and the canceller's residual for the same slot. Samples are linear 16-bit two's-complement values. The stage looks up a small configuration entry for the slot. It then chooses between the raw send sample and the cancelled sample. On the cancelled sample it can apply one of three fixed attenuation steps. Finally it can carry the send-path least significant bit through, so that robbed-bit signalling survives the processing.

A frame holds 16 or 32 timeslots, selected by the `frame32` input. In 16-slot mode the top bit of the slot index is ignored. Configuration entries are written through a plain address, data and write-enable port, with one entry per slot. The result appears registered one clock after the input sample, together with its slot index.

Top module: `slot_atten_top`

## Requirements
- R1: During and directly after reset, `out_valid` is 0, `out_smp` is 0 and `out_slot` is 0. Every configuration entry is 0, which means cancelling off, bypass off and attenuation code 00.
- R2: A sample presented with `in_valid`=1 produces `out_valid`=1 on the next clock, carrying that sample's (effective) slot index. A cycle with `in_valid`=0 produces `out_valid`=0 and leaves `out_smp` and `out_slot` unchanged.
- R3: While `cfg_we`=1, `cfg_wdata` is stored into the entry at `cfg_addr`. Bit 0 is cancel-enable, bit 1 is bypass and bits 3:2 are the attenuation code. The new entry applies to samples presented from the next cycle on.
- R4: With cancelling enabled, no bypass and attenuation code 00 or 11, the output equals the cancelled sample (0 dB).
- R5: With cancelling enabled, no bypass and code 01 (2.5 dB), the output is floor((c*24573 + 16384) / 32768) for cancelled sample c, saturated to the 16-bit signed range.
- R6: With cancelling enabled, no bypass and code 10 (6 dB), the output is the cancelled sample arithmetically shifted right by one.
- R7: With cancelling disabled and no bypass, the attenuation code is ignored and the output equals the cancelled sample.
- R8: With bypass set, the output equals the send sample, whatever the cancel-enable and attenuation settings are.
- R9: When `sig_lsb_en`=1 with the sample, output bit 0 equals bit 0 of the send sample. This holds in every mode, bypass included. All other output bits follow R4 to R8.
- R10: With `frame32`=0, slot index bit 4 is ignored: slot s uses the entry of slot s mod 16, and `out_slot` is s mod 16. With `frame32`=1 all 32 entries and the full index are used.
- R11: Writing the entry of one slot does not change the output of any other slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame32 | input | 1 | 1: 32-slot frame, 0: 16-slot frame |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 5 | Configuration entry index |
| cfg_wdata | input | 4 | Entry data: [0] cancel-enable, [1] bypass, [3:2] attenuation code |
| in_valid | input | 1 | Input sample valid |
| in_slot | input | 5 | Timeslot index of the input sample |
| send_smp | input | 16 | Original send-path sample |
| canc_smp | input | 16 | Echo-cancelled sample |
| sig_lsb_en | input | 1 | Pass the send-path LSB to the output |
| out_valid | output | 1 | Output sample valid |
| out_slot | output | 5 | Timeslot index of the output sample |
| out_smp | output | 16 | Output sample |

## Verification
Several properties are checked on every cycle, each across the output register and against the configuration entry read for the slot. These are the valid timing, the bypass path, LSB transparency, the pass-through when cancelling is off, and the 6 dB shift. The bench's scenarios are the only way to show other results. These are the rounded 2.5 dB values at the range extremes, the reserved code acting as 0 dB, and the aliasing of slots in the 16-slot frame. They also cover the independence of entries and the reset contents of the configuration file.

// File: rtl/slot_atten_pkg.sv
// Package: shared types for the per-timeslot output attenuation stage.
// Assumes a 4-bit configuration entry whose field order the write port exposes.
package slot_atten_pkg;

    typedef enum logic [1:0] {
        ATT_0DB   = 2'b00,
        ATT_2P5DB = 2'b01,
        ATT_6DB   = 2'b10,
        ATT_RSVD  = 2'b11
    } att_code_e;

    typedef struct packed {
        att_code_e att;
        logic      bypass;
        logic      cancel_en;
    } slot_cfg_t;

    localparam int CFG_W = $bits(slot_cfg_t);

endpackage

// File: rtl/slot_cfg_regs.sv
// Module: per-timeslot configuration register file.
// One entry per slot, written synchronously and read combinationally.
// A read in the same cycle as a write to that entry returns the old value.
module slot_cfg_regs
    import slot_atten_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    localparam int IDX_W = $clog2(NUM_SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [CFG_W-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output slot_cfg_t        rd_cfg
);

    slot_cfg_t entries [NUM_SLOTS];

    // Clear every entry on reset; store one entry per write cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                entries[i] <= '0;
            end
        end else if (wr_en) begin
            entries[wr_idx] <= slot_cfg_t'(wr_data);
        end
    end

    // Present the entry of the slot being processed.
    always_comb begin
        rd_cfg = entries[rd_idx];
    end

endmodule

// File: rtl/slot_gain.sv
// Module: fixed three-step attenuator for one sample.
// The 2.5 dB step is a Q-format multiply with round-half-up and saturation.
// The 6 dB step is an arithmetic shift right by one. Codes 00 and 11 pass through.
module slot_gain
    import slot_atten_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int COEF_W   = 16,
    parameter int FRAC_W   = 15,
    parameter int COEF     = 24573,
    localparam int PROD_W  = SAMPLE_W + COEF_W
) (
    input  logic [SAMPLE_W-1:0] din,
    input  att_code_e           code,
    output logic [SAMPLE_W-1:0] dout
);

    localparam logic signed [PROD_W-1:0] SMAX = PROD_W'((2 ** (SAMPLE_W - 1)) - 1);
    localparam logic signed [PROD_W-1:0] SMIN = -(PROD_W'(2 ** (SAMPLE_W - 1)));
    localparam logic signed [PROD_W-1:0] HALF = PROD_W'(2 ** (FRAC_W - 1));
    localparam logic signed [COEF_W-1:0] KCOEF = COEF_W'(COEF);

    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] scaled;
    logic [SAMPLE_W-1:0]      mul_sat;

    // Multiply by the 2.5 dB coefficient, round and saturate.
    always_comb begin
        prod   = PROD_W'($signed(din)) * PROD_W'(KCOEF);
        scaled = (prod + HALF) >>> FRAC_W;
        if (scaled > SMAX) begin
            mul_sat = SMAX[SAMPLE_W-1:0];
        end else if (scaled < SMIN) begin
            mul_sat = SMIN[SAMPLE_W-1:0];
        end else begin
            mul_sat = scaled[SAMPLE_W-1:0];
        end
    end

    // Choose the attenuation step selected by the code.
    always_comb begin
        unique case (code)
            ATT_2P5DB: dout = mul_sat;
            ATT_6DB:   dout = {din[SAMPLE_W-1], din[SAMPLE_W-1:1]};
            default:   dout = din;
        endcase
    end

endmodule

// File: rtl/slot_path_sel.sv
// Module: output source selection and signalling-bit merge.
// Precedence: bypass, then attenuation (only with cancelling enabled),
// then the LSB override, which also applies in bypass.
module slot_path_sel
    import slot_atten_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  slot_cfg_t           cfg,
    input  logic [SAMPLE_W-1:0] send_smp,
    input  logic [SAMPLE_W-1:0] canc_smp,
    input  logic [SAMPLE_W-1:0] gain_smp,
    input  logic                lsb_keep,
    output logic [SAMPLE_W-1:0] sel_smp
);

    logic [SAMPLE_W-1:0] body;

    // Pick bypass, attenuated or plain cancelled sample.
    always_comb begin
        if (cfg.bypass) begin
            body = send_smp;
        end else if (cfg.cancel_en) begin
            body = gain_smp;
        end else begin
            body = canc_smp;
        end
    end

    // Carry the send-path LSB through when signalling is active.
    always_comb begin
        sel_smp = body;
        if (lsb_keep) begin
            sel_smp[0] = send_smp[0];
        end
    end

endmodule

// File: rtl/slot_atten_top.sv
// Module: per-timeslot output attenuation stage, top level.
// Looks up the slot's entry, forms the output sample and registers it
// together with its slot index one clock after a valid input.
module slot_atten_top
    import slot_atten_pkg::*;
#(
    parameter int SAMPLE_W  = 16,
    parameter int MAX_SLOTS = 32,
    localparam int IDX_W    = $clog2(MAX_SLOTS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame32,
    input  logic                cfg_we,
    input  logic [IDX_W-1:0]    cfg_addr,
    input  logic [CFG_W-1:0]    cfg_wdata,
    input  logic                in_valid,
    input  logic [IDX_W-1:0]    in_slot,
    input  logic [SAMPLE_W-1:0] send_smp,
    input  logic [SAMPLE_W-1:0] canc_smp,
    input  logic                sig_lsb_en,
    output logic                out_valid,
    output logic [IDX_W-1:0]    out_slot,
    output logic [SAMPLE_W-1:0] out_smp
);

    logic [IDX_W-1:0]    eff_slot;
    slot_cfg_t           cur_cfg;
    logic [SAMPLE_W-1:0] gain_smp;
    logic [SAMPLE_W-1:0] sel_smp;

    // Drop the top index bit in the 16-slot frame.
    always_comb begin
        eff_slot = in_slot;
        if (!frame32) begin
            eff_slot[IDX_W-1] = 1'b0;
        end
    end

    slot_cfg_regs #(
        .NUM_SLOTS(MAX_SLOTS)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_we),
        .wr_idx (cfg_addr),
        .wr_data(cfg_wdata),
        .rd_idx (eff_slot),
        .rd_cfg (cur_cfg)
    );

    slot_gain #(
        .SAMPLE_W(SAMPLE_W)
    ) u_gain (
        .din (canc_smp),
        .code(cur_cfg.att),
        .dout(gain_smp)
    );

    slot_path_sel #(
        .SAMPLE_W(SAMPLE_W)
    ) u_sel (
        .cfg     (cur_cfg),
        .send_smp(send_smp),
        .canc_smp(canc_smp),
        .gain_smp(gain_smp),
        .lsb_keep(sig_lsb_en),
        .sel_smp (sel_smp)
    );

    // Register the result and its slot index on each valid input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_slot  <= '0;
            out_smp   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_slot <= eff_slot;
                out_smp  <= sel_smp;
            end
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_valid == $past(in_valid))); // R2

    AST_BYPASS_SEND: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cur_cfg.bypass && !sig_lsb_en) |=> (out_smp == $past(send_smp))); // R8

    AST_LSB_TRANSPARENT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sig_lsb_en) |=> (out_smp[0] == $past(send_smp[0]))); // R9

    AST_NO_CANCEL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cur_cfg.bypass && !cur_cfg.cancel_en && !sig_lsb_en)
        |=> (out_smp == $past(canc_smp))); // R7

    AST_HALF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cur_cfg.bypass && cur_cfg.cancel_en && cur_cfg.att == ATT_6DB && !sig_lsb_en)
        |=> ($signed(out_smp) == ($signed($past(canc_smp)) >>> 1))); // R6

endmodule

// File: tb/slot_atten_top_tb.sv
`timescale 1ns/1ps
module slot_atten_top_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        frame32;
    logic        cfg_we;
    logic [4:0]  cfg_addr;
    logic [3:0]  cfg_wdata;
    logic        in_valid;
    logic [4:0]  in_slot;
    logic [15:0] send_smp;
    logic [15:0] canc_smp;
    logic        sig_lsb_en;
    logic        out_valid;
    logic [4:0]  out_slot;
    logic [15:0] out_smp;

    int n_checks = 0;
    int n_fail   = 0;
    logic [3:0] model [32];

    always #2.5 clk = ~clk;

    slot_atten_top u_dut (
        .clk(clk), .rst_n(rst_n), .frame32(frame32), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .in_valid(in_valid),
        .in_slot(in_slot), .send_smp(send_smp), .canc_smp(canc_smp),
        .sig_lsb_en(sig_lsb_en), .out_valid(out_valid), .out_slot(out_slot),
        .out_smp(out_smp)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] expect_out(input logic [3:0] c, input logic [15:0] s,
                                               input logic [15:0] k, input logic sig);
        int x;
        logic [15:0] r;
        x = int'($signed(k));
        if (c[1]) r = s;
        else if (!c[0]) r = k;
        else if (c[3:2] == 2'b01) begin
            x = (x * 24573 + 16384) >>> 15;
            if (x > 32767) x = 32767;
            if (x < -32768) x = -32768;
            r = 16'(x);
        end else if (c[3:2] == 2'b10) r = 16'(x >>> 1);
        else r = k;
        if (sig) r[0] = s[0];
        return r;
    endfunction

    task automatic write_cfg(input logic [4:0] a, input logic [3:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        model[a] = d;
    endtask

    // Present one sample, then check the registered result a clock later.
    task automatic push(input string req, input logic [4:0] slot, input logic [15:0] s,
                        input logic [15:0] k, input logic sig);
        logic [4:0] es;
        es = frame32 ? slot : {1'b0, slot[3:0]};
        @(negedge clk);
        in_valid = 1'b1; in_slot = slot; send_smp = s; canc_smp = k; sig_lsb_en = sig;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " value"}, int'(out_smp), int'(expect_out(model[es], s, k, sig)));
        check({req, " valid"}, int'(out_valid), 1);
        check({req, " slot"}, int'(out_slot), int'(es));
    endtask

    task automatic t_reset();
        check("R1 out_valid", int'(out_valid), 0);
        check("R1 out_smp", int'(out_smp), 0);
        check("R1 out_slot", int'(out_slot), 0);
        push("R1 default entry", 5'd9, 16'h1234, 16'h0F0F, 1'b0);
    endtask

    task automatic t_zero_db();
        write_cfg(5'd3, 4'b0001);
        push("R4 code00", 5'd3, 16'h1111, 16'h8001, 1'b0);
        write_cfg(5'd3, 4'b1101);
        push("R4 code11", 5'd3, 16'h1111, 16'h7ABC, 1'b0);
    endtask

    task automatic t_two_five();
        write_cfg(5'd5, 4'b0101);
        push("R5 pos", 5'd5, 16'h0, 16'd1000, 1'b0);
        push("R5 max", 5'd5, 16'h0, 16'h7FFF, 1'b0);
        push("R5 min", 5'd5, 16'h0, 16'h8000, 1'b0);
        push("R5 minus1", 5'd5, 16'h0, 16'hFFFF, 1'b0);
        push("R5 minus3", 5'd5, 16'h0, 16'hFFFD, 1'b0);
        check("R5 literal 1000", int'(expect_out(4'b0101, 16'h0, 16'd1000, 1'b0)), 750);
    endtask

    task automatic t_six();
        write_cfg(5'd6, 4'b1001);
        push("R6 odd neg", 5'd6, 16'h0, 16'hFFFD, 1'b0);
        push("R6 pos", 5'd6, 16'h0, 16'd301, 1'b0);
        push("R6 min", 5'd6, 16'h0, 16'h8000, 1'b0);
    endtask

    task automatic t_cancel_off();
        write_cfg(5'd7, 4'b1000);
        push("R7 code ignored", 5'd7, 16'h2222, 16'h4321, 1'b0);
        check("R7 literal", int'(out_smp), 16'h4321);
    endtask

    task automatic t_bypass();
        write_cfg(5'd8, 4'b1011);
        push("R8 bypass", 5'd8, 16'hBEEF, 16'h1234, 1'b0);
        check("R8 literal", int'(out_smp), 16'hBEEF);
    endtask

    task automatic t_lsb();
        push("R9 bypass lsb", 5'd8, 16'hBEEE, 16'h1235, 1'b1);
        push("R9 atten lsb", 5'd6, 16'h0001, 16'h0100, 1'b1);
        check("R9 literal", int'(out_smp), 16'h0081);
        push("R9 plain lsb", 5'd7, 16'h0000, 16'h7FFF, 1'b1);
    endtask

    task automatic t_frame();
        write_cfg(5'd4, 4'b1001);
        write_cfg(5'd20, 4'b0010);
        frame32 = 1'b0;
        push("R10 alias16", 5'd20, 16'h5555, 16'h0100, 1'b0);
        check("R10 alias literal", int'(out_smp), 16'h0080);
        frame32 = 1'b1;
        push("R10 full32", 5'd20, 16'h5555, 16'h0100, 1'b0);
        push("R10 full32 low", 5'd4, 16'h5555, 16'h0100, 1'b0);
    endtask

    task automatic t_indep();
        write_cfg(5'd10, 4'b0010);
        push("R11 neighbour 11", 5'd11, 16'h0A0A, 16'h0B0B, 1'b0);
        push("R11 neighbour 9", 5'd9, 16'h0A0A, 16'h0B0B, 1'b0);
        push("R3 written slot", 5'd10, 16'h0A0A, 16'h0B0B, 1'b0);
    endtask

    task automatic t_hold();
        push("R2 setup", 5'd12, 16'h0, 16'h3333, 1'b0);
        @(negedge clk);
        canc_smp = 16'h4444; in_slot = 5'd13;
        @(negedge clk);
        check("R2 idle valid", int'(out_valid), 0);
        check("R2 hold smp", int'(out_smp), 16'h3333);
        check("R2 hold slot", int'(out_slot), 12);
    endtask

    initial begin
        #100000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) model[i] = 4'b0;
        rst_n = 1'b0; frame32 = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        in_valid = 1'b0; in_slot = '0; send_smp = '0; canc_smp = '0; sig_lsb_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_zero_db();
        t_two_five();
        t_six();
        t_cancel_off();
        t_bypass();
        t_lsb();
        t_frame();
        t_indep();
        t_hold();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule